// File: doc/BRIEF.md
# CPU-cycle countdown interrupt timer

This block is an interrupt timer built around a 15-bit down-counter that advances once for every CPU cycle strobe. Software programs it through two write slots sharing one 8-bit data bus: a low-byte slot that only buffers the lower eight bits of the reload value, and a high-byte slot. A write to the high-byte slot loads all fifteen counter bits in one step, takes the enable from its top data bit and acknowledges any pending interrupt.

While enabled, the counter counts CPU cycle strobes down to zero. On the strobe that brings it to zero, the block raises an active-high, sticky pending output, which stays set until the next high-byte write. Address decoding around the two slots and the processor's interrupt logic sit outside the block. The block sees only the cycle strobe, the two write strobes and the data byte.

Top module: `cyc_irq_timer`

## Requirements
- R1: A pulse on `wr_lo` stores `wr_data` in the low-byte buffer only. The counter, the enable and the pending flag keep their values until the next `wr_hi` pulse.
- R2: A pulse on `wr_hi` loads the counter with {`wr_data`[6:0], low-byte buffer}. The buffer value used is the one held before the edge, even when `wr_lo` pulses in the same cycle, in which case the buffer takes the new byte for later loads.
- R3: A pulse on `wr_hi` sets the enable to `wr_data`[7] (1 = counting, 0 = stopped).
- R4: Every `wr_hi` pulse clears `irq_pend` on the following clock. A `wr_hi` pulse takes priority over a `cyc_stb` in the same cycle: that strobe does not count against the value just loaded.
- R5: While enabled, each clock with `cyc_stb` high decrements the counter by one, and clocks without `cyc_stb` leave it unchanged. After a load of N ≥ 1, `irq_pend` is low after N-1 strobes and is high one clock after the Nth strobe.
- R6: A load of zero with the enable set raises `irq_pend` one clock after the first strobe that follows the load.
- R7: Once the count has expired, the counter holds at zero and `irq_pend` stays high through further strobes until a `wr_hi` pulse.
- R8: While the enable is clear, strobes neither decrement the counter nor set `irq_pend`.
- R9: An active-low `rst_n` clears the counter, the low-byte buffer, the enable and `irq_pend`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | One-clock pulse per CPU cycle |
| wr_lo | input | 1 | Write strobe for the low-byte buffer slot |
| wr_hi | input | 1 | Write strobe for the high-byte, enable and acknowledge slot |
| wr_data | input | 8 | CPU write data shared by both slots |
| irq_pend | output | 1 | Registered interrupt pending, active high |

## Verification
Every result of this block is registered. A write or a strobe sampled on one rising edge shows up on `irq_pend` in the same clock period, after that edge. The bench therefore applies stimulus on falling edges and checks the output on the next falling edge. Its reference model updates on the rising edge from the same inputs and is compared with the pending output at every falling edge. The directed checks place the N-1 and N strobe boundaries of R5 exactly by counting the strobes the bench drives, one per clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_LOAD = 2'd1,
      STEP_DEC  = 2'd2,
      STEP_HOLD = 2'd3
   } tmr_step_e;

   typedef struct packed {
      logic load;
      logic stb;
      logic en;
      logic at_floor;
   } tmr_ctl_t;

   function automatic tmr_step_e tmr_pick_step(input tmr_ctl_t c);
      tmr_step_e s;
      if (c.load)
         s = STEP_LOAD;
      else if (c.stb && c.en && !c.at_floor)
         s = STEP_DEC;
      else if (c.stb && c.en)
         s = STEP_HOLD;
      else
         s = STEP_IDLE;
      return s;
   endfunction

endpackage

// File: rtl/tmr_reload_latch.sv
module tmr_reload_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] lat_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         lat_q <= '0;
      else if (wr_lo)
         lat_q <= wr_data;
   end

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter
   import tmr_pkg::*;
#(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             load_en,
   input  logic             cyc_stb,
   output logic [CNT_W-1:0] cnt_q,
   output logic             en_q,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   tmr_ctl_t  ctl;
   tmr_step_e step;
   logic      at_floor;
   logic      near_floor;

   assign at_floor   = (cnt_q == '0);
   assign near_floor = (cnt_q[CNT_W-1:1] == '0);

   always_comb begin
      ctl.load     = load;
      ctl.stb      = cyc_stb;
      ctl.en       = en_q;
      ctl.at_floor = at_floor;
      step         = tmr_pick_step(ctl);
   end

   assign expire = (step == STEP_DEC && near_floor) || (step == STEP_HOLD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else begin
         case (step)
            STEP_LOAD: begin
               cnt_q <= load_val;
               en_q  <= load_en;
            end
            STEP_DEC:  cnt_q <= cnt_q - ONE;
            default:   cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/tmr_pend_flag.sv
module tmr_pend_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (clr)
         pend_q <= 1'b0;
      else if (set)
         pend_q <= 1'b1;
   end

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
   parameter int CNT_W  = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_stb,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wr_data,
   output logic              irq_pend
);

   localparam int HI_W   = CNT_W - DATA_W;
   localparam int EN_BIT = DATA_W - 1;

   generate
      if (CNT_W <= DATA_W) begin : g_bad_width
         $error("CNT_W must exceed DATA_W");
      end
      if (HI_W > EN_BIT) begin : g_bad_split
         $error("high count bits collide with the enable bit");
      end
   endgenerate

   logic [DATA_W-1:0] lat_q;
   logic [CNT_W-1:0]  load_val;
   logic [CNT_W-1:0]  cnt_q;
   logic              en_q;
   logic              expire;

   assign load_val = {wr_data[HI_W-1:0], lat_q};

   tmr_reload_latch #(.DATA_W(DATA_W)) u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_lo),
      .wr_data (wr_data),
      .lat_q   (lat_q)
   );

   tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_hi),
      .load_val (load_val),
      .load_en  (wr_data[EN_BIT]),
      .cyc_stb  (cyc_stb),
      .cnt_q    (cnt_q),
      .en_q     (en_q),
      .expire   (expire)
   );

   tmr_pend_flag u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (expire),
      .clr    (wr_hi),
      .pend_q (irq_pend)
   );

endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
   parameter int CNT_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cyc_stb,
   input logic             wr_lo,
   input logic             wr_hi,
   input logic             irq_pend,
   input logic [CNT_W-1:0] cnt,
   input logic             en
);

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> !irq_pend); // R4

   AST_LO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi && !cyc_stb) |=> ($stable(cnt) && $stable(en) && $stable(irq_pend))); // R1

   AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cyc_stb && !wr_hi && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5

   AST_PEND_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend) |-> (cnt == '0)); // R7

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && !wr_hi) |=> irq_pend); // R7

   AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !wr_hi) |=> ($stable(cnt) && !$rose(irq_pend))); // R8

endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cyc_stb  (cyc_stb),
   .wr_lo    (wr_lo),
   .wr_hi    (wr_hi),
   .irq_pend (irq_pend),
   .cnt      (cnt_q),
   .en       (en_q)
);

// File: tb/sim_cyc_irq_timer.sv
`timescale 1ns/1ps
module sim_cyc_irq_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_stb = 1'b0;
   logic       wr_lo = 1'b0;
   logic       wr_hi = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       irq_pend;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req = "R9";
   bit    done = 1'b0;

   int m_cnt = 0;
   int m_lat = 0;
   bit m_en = 1'b0;
   bit m_pend = 1'b0;

   always #2 clk = ~clk;

   cyc_irq_timer u0 (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .wr_lo(wr_lo),
      .wr_hi(wr_hi), .wr_data(wr_data), .irq_pend(irq_pend)
   );

   // behavioural reference, updated on the same edge as the design
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_lat = 0; m_en = 0; m_pend = 0;
      end else begin
         if (wr_hi) begin
            m_cnt  = (int'(wr_data & 8'h7f) * 256) + m_lat;
            m_en   = wr_data[7];
            m_pend = 0;
         end else if (cyc_stb && m_en) begin
            if (m_cnt <= 1) m_pend = 1;
            if (m_cnt > 0) m_cnt = m_cnt - 1;
         end
         if (wr_lo) m_lat = int'(wr_data);
      end
   end

   task automatic check(input bit act, input bit exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: irq_pend=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) check(irq_pend, m_pend, cur_req);
   end

   task automatic wr(input bit lo, input bit hi, input logic [7:0] d, input bit stb);
      @(negedge clk);
      wr_lo = lo; wr_hi = hi; wr_data = d; cyc_stb = stb;
      @(negedge clk);
      wr_lo = 0; wr_hi = 0; cyc_stb = 0;
      #1;
   endtask

   task automatic cycles(input int n, input bit stb);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cyc_stb = stb;
      end
      @(negedge clk);
      cyc_stb = 0;
      #1;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(irq_pend, 1'b0, "R9");
      rst_n = 1'b1;

      cur_req = "R1";
      wr(1, 0, 8'd10, 0);
      wr(0, 1, 8'h80, 0);
      wr(1, 0, 8'd2, 0);
      cycles(9, 1);
      check(irq_pend, 1'b0, "R1");
      cycles(1, 1);
      check(irq_pend, 1'b1, "R1");

      cur_req = "R7";
      cycles(5, 1);
      check(irq_pend, 1'b1, "R7");

      cur_req = "R4";
      wr(0, 1, 8'h00, 0);
      check(irq_pend, 1'b0, "R4");

      cur_req = "R8";
      wr(1, 0, 8'd3, 0);
      wr(0, 1, 8'h03, 0);
      cycles(1000, 1);
      check(irq_pend, 1'b0, "R8");

      cur_req = "R5";
      wr(1, 0, 8'd3, 0);
      wr(0, 1, 8'h80, 0);
      cycles(10, 0);
      check(irq_pend, 1'b0, "R5");
      cycles(2, 1);
      check(irq_pend, 1'b0, "R5");
      cycles(1, 1);
      check(irq_pend, 1'b1, "R5");

      cur_req = "R3";
      wr(1, 0, 8'd3, 0);
      wr(0, 1, 8'h00, 0);
      cycles(50, 1);
      check(irq_pend, 1'b0, "R3");
      wr(0, 1, 8'h80, 0);
      cycles(2, 1);
      check(irq_pend, 1'b0, "R3");
      cycles(1, 1);
      check(irq_pend, 1'b1, "R3");

      cur_req = "R6";
      wr(1, 0, 8'd0, 0);
      wr(0, 1, 8'h80, 0);
      check(irq_pend, 1'b0, "R6");
      cycles(1, 1);
      check(irq_pend, 1'b1, "R6");

      cur_req = "R2";
      wr(1, 0, 8'hff, 0);
      wr(0, 1, 8'hff, 0);
      cycles(32766, 1);
      check(irq_pend, 1'b0, "R2");
      cycles(1, 1);
      check(irq_pend, 1'b1, "R2");
      wr(1, 0, 8'd5, 0);
      wr(1, 1, 8'h80, 0);
      cycles(4, 1);
      check(irq_pend, 1'b0, "R2");
      cycles(1, 1);
      check(irq_pend, 1'b1, "R2");
      wr(0, 1, 8'h80, 0);
      cycles(127, 1);
      check(irq_pend, 1'b0, "R2");
      cycles(1, 1);
      check(irq_pend, 1'b1, "R2");

      cur_req = "R4";
      wr(1, 0, 8'd3, 0);
      wr(0, 1, 8'h80, 1);
      check(irq_pend, 1'b0, "R4");
      cycles(2, 1);
      check(irq_pend, 1'b0, "R4");
      cycles(1, 1);
      check(irq_pend, 1'b1, "R4");

      cur_req = "R9";
      wr(1, 0, 8'h40, 0);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      check(irq_pend, 1'b0, "R9");
      rst_n = 1'b1;
      wr(0, 1, 8'h80, 0);
      cycles(1, 1);
      check(irq_pend, 1'b1, "R9");

      cycles(3, 0);
      finish_run();
   end

endmodule